// File: doc/BRIEF.md
# Serial Flash Modify-Command Guard

This block decides whether a program, erase or status-write command sent to a small serial NOR flash may go ahead. An SPI front end hands it one strobe per command, asserted in the cycle in which chip select rises. With that strobe come the opcode, the number of bits clocked while chip select was low, the 24-bit target address and the first data byte. The guard holds the write-enable latch, a three-bit protect level, the status-write lock bit and a deep-power-down flag. These are exported for the status-read path.

For every modify request the block issues exactly one decision: a one-cycle accept pulse or a one-cycle reject pulse, in the cycle after the strobe. A request is accepted only when four things hold: the latch is set, the command length is a whole number of bytes and at least the opcode's minimum, the device is awake, and the target block lies outside the protected range. An accepted request clears the latch. A rejected one leaves all state as it was. The array is eight 64 KB blocks, and the block index is address bits [18:16].

Top module: `flash_wrguard`

## Requirements
- R1: After reset the latch, protect level, lock bit, deep-power-down flag, accept and reject outputs are all 0.
- R2: A well-formed opcode 0x06 sets the latch. A well-formed opcode 0x04 clears it.
- R3: The modify opcodes are 0x02 (page program), 0x20 (sector erase), 0xD8 (block erase), 0x60 or 0xC7 (chip erase) and 0x01 (status write). Each strobe with a modify opcode gives exactly one of accept or reject. Any other opcode gives neither.
- R4: A modify request is rejected when the latch is 0. An accepted request clears the latch. A rejected request leaves the latch, protect level and lock bit unchanged.
- R5: A strobe is well-formed only when the bit count is a multiple of 8 and at least the opcode's minimum: 40 for 0x02, 32 for 0x20 and 0xD8, 16 for 0x01, and 8 for all others. A malformed strobe changes no state, and a malformed modify request is rejected.
- R6: A program or sector/block erase is rejected when its block, address[18:16], is protected. Level 0 protects nothing, level 1 protects block 7, level 2 protects blocks 6–7, level 3 protects blocks 4–7, and levels 4–7 protect all blocks.
- R7: A chip erase is rejected whenever the protect level is not 0.
- R8: An accepted status write loads the protect level from data bits [4:2] and the lock bit from data bit 7. A status write is rejected when the lock bit is 1 and the protect pin is low. Nothing else changes the level or the lock bit.
- R9: Well-formed opcode 0xB9 enters deep power down. While in it, every strobe is ignored except a well-formed 0xAB, which leaves it. Modify requests in this state are rejected.
- R10: Accept and reject are registered pulses. Each lasts one cycle, in the cycle after the strobe, and neither is asserted in a cycle that does not follow a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wp_ni | input | 1 | Hardware protect pin, active low |
| cs_rise_i | input | 1 | One-cycle strobe: chip select has risen, command ended |
| op_i | input | 8 | Opcode of the ended command |
| nbits_i | input | 12 | Bits clocked while chip select was low |
| addr_i | input | 24 | Target address of the command |
| wdata_i | input | 8 | First data byte (status value for a status write) |
| accept_o | output | 1 | Modify request accepted (one-cycle pulse) |
| reject_o | output | 1 | Modify request rejected (one-cycle pulse) |
| wel_o | output | 1 | Write-enable latch |
| bp_o | output | 3 | Protect level |
| srwd_o | output | 1 | Status-write lock bit |
| dpd_o | output | 1 | Deep-power-down flag |

## Verification
The assertions assume that opcode, bit count, address, data and the protect pin are stable and defined whenever the strobe is high. They also assume the strobe is held low while the internal reset is still asserted. The bench changes inputs only on the falling clock edge. It raises the strobe for a single cycle and follows each strobe with at least one idle cycle, so every decision pulse can be seen alone. It sweeps all eight protect levels against all eight blocks. It drives malformed lengths, which are either not byte-aligned or shorter than the opcode's minimum. It also toggles the protect pin with the lock bit both set and clear.

// File: rtl/wrg_pkg.sv
package wrg_pkg;
  localparam int PROT_W = 3;

  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_WRDI = 8'h04;
  localparam logic [7:0] OP_WRSR = 8'h01;
  localparam logic [7:0] OP_PP   = 8'h02;
  localparam logic [7:0] OP_SE   = 8'h20;
  localparam logic [7:0] OP_BE   = 8'hD8;
  localparam logic [7:0] OP_CE_A = 8'h60;
  localparam logic [7:0] OP_CE_B = 8'hC7;
  localparam logic [7:0] OP_DP   = 8'hB9;
  localparam logic [7:0] OP_WAKE = 8'hAB;

  typedef enum logic [2:0] {
    K_OTHER, K_SETWE, K_CLRWE, K_STWR, K_ADDRMOD, K_CHIP, K_SLEEP, K_WAKE
  } kind_e;

  typedef struct packed {
    logic              lock;
    logic [PROT_W-1:0] lvl;
    logic              wel;
    logic              dpd;
  } guard_st_t;
endpackage

// File: rtl/wrg_decode.sv
module wrg_decode
  import wrg_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic [7:0]       op_i,
  input  logic [CNT_W-1:0] nbits_i,
  output kind_e            kind_o,
  output logic             modify_o,
  output logic             len_ok_o
);
  logic [CNT_W-1:0] min_len;

  always_comb begin
    case (op_i)
      OP_PP:        min_len = CNT_W'(40);
      OP_SE, OP_BE: min_len = CNT_W'(32);
      OP_WRSR:      min_len = CNT_W'(16);
      default:      min_len = CNT_W'(8);
    endcase
  end

  always_comb begin
    case (op_i)
      OP_WREN:              kind_o = K_SETWE;
      OP_WRDI:              kind_o = K_CLRWE;
      OP_WRSR:              kind_o = K_STWR;
      OP_PP, OP_SE, OP_BE:  kind_o = K_ADDRMOD;
      OP_CE_A, OP_CE_B:     kind_o = K_CHIP;
      OP_DP:                kind_o = K_SLEEP;
      OP_WAKE:              kind_o = K_WAKE;
      default:              kind_o = K_OTHER;
    endcase
  end

  assign modify_o = (kind_o == K_STWR) || (kind_o == K_ADDRMOD) || (kind_o == K_CHIP);
  assign len_ok_o = (nbits_i[2:0] == 3'b000) && (nbits_i >= min_len);
endmodule

// File: rtl/wrg_prot.sv
module wrg_prot #(
  parameter int BLK_W = 3,
  parameter int LVL_W = 3
) (
  input  logic [LVL_W-1:0] lvl_i,
  input  logic [BLK_W-1:0] blk_i,
  output logic             hit_o
);
  localparam logic [BLK_W:0] NBLK = {1'b1, {BLK_W{1'b0}}};

  logic [BLK_W:0] span;
  logic [BLK_W:0] floor_blk;

  // protected range grows downward from the top block in powers of two
  always_comb begin
    span      = '0;
    floor_blk = '0;
    if (lvl_i == '0) begin
      hit_o = 1'b0;
    end else if (lvl_i > LVL_W'(BLK_W)) begin
      hit_o = 1'b1;
    end else begin
      span      = (BLK_W+1)'(1) << (lvl_i - LVL_W'(1));
      floor_blk = NBLK - span;
      hit_o     = ({1'b0, blk_i} >= floor_blk);
    end
  end
endmodule

// File: rtl/wrg_state.sv
module wrg_state
  import wrg_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      fire_i,
  input  kind_e     kind_i,
  input  logic      modify_i,
  input  logic      len_ok_i,
  input  logic      hit_i,
  input  logic      wp_ni,
  input  logic [7:0] wdata_i,
  output guard_st_t st_o,
  output logic      acc_o,
  output logic      rej_o
);
  guard_st_t st_q, st_d;
  logic      acc_d, rej_d;
  logic      hw_locked;

  assign hw_locked = st_q.lock && !wp_ni;

  always_comb begin
    st_d  = st_q;
    acc_d = 1'b0;
    rej_d = 1'b0;
    if (fire_i) begin
      if (st_q.dpd) begin
        if (kind_i == K_WAKE && len_ok_i) st_d.dpd = 1'b0;
        rej_d = modify_i;
      end else if (!len_ok_i) begin
        rej_d = modify_i;
      end else begin
        case (kind_i)
          K_SETWE: st_d.wel = 1'b1;
          K_CLRWE: st_d.wel = 1'b0;
          K_SLEEP: st_d.dpd = 1'b1;
          K_STWR: begin
            if (st_q.wel && !hw_locked) begin
              acc_d      = 1'b1;
              st_d.wel   = 1'b0;
              st_d.lvl   = wdata_i[2 +: PROT_W];
              st_d.lock  = wdata_i[7];
            end else begin
              rej_d = 1'b1;
            end
          end
          K_ADDRMOD: begin
            if (st_q.wel && !hit_i) begin
              acc_d    = 1'b1;
              st_d.wel = 1'b0;
            end else begin
              rej_d = 1'b1;
            end
          end
          K_CHIP: begin
            if (st_q.wel && (st_q.lvl == '0)) begin
              acc_d    = 1'b1;
              st_d.wel = 1'b0;
            end else begin
              rej_d = 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= '0;
    end else if (fire_i) begin
      st_q <= st_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_o <= 1'b0;
      rej_o <= 1'b0;
    end else begin
      acc_o <= acc_d;
      rej_o <= rej_d;
    end
  end

  assign st_o = st_q;
endmodule

// File: rtl/flash_wrguard.sv
module flash_wrguard
  import wrg_pkg::*;
#(
  parameter int CNT_W   = 12,
  parameter int ADDR_W  = 24,
  parameter int BLK_W   = 3,
  parameter int BLK_LSB = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wp_ni,
  input  logic              cs_rise_i,
  input  logic [7:0]        op_i,
  input  logic [CNT_W-1:0]  nbits_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic              accept_o,
  output logic              reject_o,
  output logic              wel_o,
  output logic [PROT_W-1:0] bp_o,
  output logic              srwd_o,
  output logic              dpd_o
);
  logic [1:0] rst_pipe;
  logic       rst_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_pipe <= 2'b00;
    else         rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q = rst_pipe[1];

  kind_e     kind;
  logic      modify, len_ok, hit;
  guard_st_t st;

  wrg_decode #(.CNT_W(CNT_W)) u_dec (
    .op_i     (op_i),
    .nbits_i  (nbits_i),
    .kind_o   (kind),
    .modify_o (modify),
    .len_ok_o (len_ok)
  );

  wrg_prot #(.BLK_W(BLK_W), .LVL_W(PROT_W)) u_prot (
    .lvl_i (st.lvl),
    .blk_i (addr_i[BLK_LSB +: BLK_W]),
    .hit_o (hit)
  );

  wrg_state u_st (
    .clk_i    (clk_i),
    .rst_ni   (rst_q),
    .fire_i   (cs_rise_i),
    .kind_i   (kind),
    .modify_i (modify),
    .len_ok_i (len_ok),
    .hit_i    (hit),
    .wp_ni    (wp_ni),
    .wdata_i  (wdata_i),
    .st_o     (st),
    .acc_o    (accept_o),
    .rej_o    (reject_o)
  );

  assign wel_o  = st.wel;
  assign bp_o   = st.lvl;
  assign srwd_o = st.lock;
  assign dpd_o  = st.dpd;
endmodule

// File: rtl/wrg_chk.sv
module wrg_chk
  import wrg_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input logic              clk_i,
  input logic              rst_n,
  input logic              cs_rise_i,
  input logic [7:0]        op_i,
  input logic [CNT_W-1:0]  nbits_i,
  input logic              accept_o,
  input logic              reject_o,
  input logic              wel_o,
  input logic [PROT_W-1:0] bp_o,
  input logic              srwd_o,
  input logic              dpd_o
);
  logic live;
  logic op_mod;
  logic op_chip;

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) live <= 1'b0;
    else        live <= 1'b1;
  end

  assign op_mod  = (op_i == OP_PP) || (op_i == OP_SE) || (op_i == OP_BE) ||
                   (op_i == OP_CE_A) || (op_i == OP_CE_B) || (op_i == OP_WRSR);
  assign op_chip = (op_i == OP_CE_A) || (op_i == OP_CE_B);

  // R3
  one_decision_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    !(accept_o && reject_o));

  // R3
  decide_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (live && $past(cs_rise_i && op_mod)) |-> (accept_o || reject_o));

  // R4
  acc_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    accept_o |-> !wel_o);

  // R4
  acc_needs_wel_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (live && accept_o) |-> $past(wel_o));

  // R5
  frac_len_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (live && $past(cs_rise_i && (nbits_i[2:0] != 3'b000)))
      |-> (!accept_o && (wel_o == $past(wel_o)) && (dpd_o == $past(dpd_o))));

  // R7
  chip_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (live && accept_o && $past(op_chip)) |-> ($past(bp_o) == '0));

  // R8
  prot_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (live && !accept_o) |-> ($stable(bp_o) && $stable(srwd_o)));

  // R9
  sleep_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (live && $past(dpd_o)) |-> !accept_o);

  // R10
  no_spont_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (live && !$past(cs_rise_i)) |-> (!accept_o && !reject_o));
endmodule

bind flash_wrguard wrg_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_n     (rst_q),
  .cs_rise_i (cs_rise_i),
  .op_i      (op_i),
  .nbits_i   (nbits_i),
  .accept_o  (accept_o),
  .reject_o  (reject_o),
  .wel_o     (wel_o),
  .bp_o      (bp_o),
  .srwd_o    (srwd_o),
  .dpd_o     (dpd_o)
);

// File: tb/sim_flash_wrguard.sv
`timescale 1ns/1ps
module sim_flash_wrguard;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wp_n = 1'b1;
  logic        cs = 1'b0;
  logic [7:0]  op = 8'h00;
  logic [11:0] nb = 12'd0;
  logic [23:0] ad = 24'd0;
  logic [7:0]  wd = 8'h00;
  logic        acc, rej, wel, srwd, dpd;
  logic [2:0]  bp;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // behavioural model state
  bit m_wel, m_lock, m_dpd;
  int m_lvl;

  always #4 clk = ~clk;

  flash_wrguard u0 (
    .clk_i(clk), .rst_ni(rst_n), .wp_ni(wp_n), .cs_rise_i(cs), .op_i(op),
    .nbits_i(nb), .addr_i(ad), .wdata_i(wd), .accept_o(acc), .reject_o(rej),
    .wel_o(wel), .bp_o(bp), .srwd_o(srwd), .dpd_o(dpd)
  );

  function automatic int min_bits(input int code);
    if (code == 8'h02) return 40;
    if (code == 8'h20 || code == 8'hD8) return 32;
    if (code == 8'h01) return 16;
    return 8;
  endfunction

  function automatic bit blk_locked(input int lvl, input int blk);
    if (lvl == 0) return 0;
    if (lvl == 1) return blk == 7;
    if (lvl == 2) return blk >= 6;
    if (lvl == 3) return blk >= 4;
    return 1;
  endfunction

  task automatic compare(input bit ea, input bit er, input string tag);
    checks++;
    if (acc !== ea || rej !== er || wel !== m_wel || bp !== 3'(m_lvl) ||
        srwd !== m_lock || dpd !== m_dpd) begin
      errors++;
      $display("FAIL %s: acc=%0b rej=%0b wel=%0b bp=%0d lock=%0b dpd=%0b expected acc=%0b rej=%0b wel=%0b bp=%0d lock=%0b dpd=%0b",
               tag, acc, rej, wel, bp, srwd, dpd, ea, er, m_wel, m_lvl, m_lock, m_dpd);
    end
  endtask

  task automatic cmd(input int code, input int bits, input int blk, input int data, input string tag);
    bit is_mod, ok, ea, er;
    ea = 0; er = 0;
    is_mod = (code == 8'h01 || code == 8'h02 || code == 8'h20 || code == 8'hD8 ||
              code == 8'h60 || code == 8'hC7);
    ok = (bits % 8 == 0) && (bits >= min_bits(code));
    if (m_dpd) begin
      if (code == 8'hAB && ok) m_dpd = 0;
      er = is_mod;
    end else if (!ok) begin
      er = is_mod;
    end else if (code == 8'h06) m_wel = 1;
    else if (code == 8'h04) m_wel = 0;
    else if (code == 8'hB9) m_dpd = 1;
    else if (code == 8'h01) begin
      if (m_wel && !(m_lock && !wp_n)) begin
        ea = 1; m_wel = 0; m_lvl = (data >> 2) & 7; m_lock = (data >> 7) & 1;
      end else er = 1;
    end else if (code == 8'h02 || code == 8'h20 || code == 8'hD8) begin
      if (m_wel && !blk_locked(m_lvl, blk)) begin ea = 1; m_wel = 0; end
      else er = 1;
    end else if (code == 8'h60 || code == 8'hC7) begin
      if (m_wel && m_lvl == 0) begin ea = 1; m_wel = 0; end
      else er = 1;
    end
    @(negedge clk);
    cs = 1'b1; op = 8'(code); nb = 12'(bits); ad = 24'(blk << 16) | 24'h00_1234; wd = 8'(data);
    @(negedge clk);
    cs = 1'b0;
    compare(ea, er, tag);
    @(negedge clk);
    compare(0, 0, "R10 idle after pulse");
  endtask

  initial begin
    #800000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    m_wel = 0; m_lock = 0; m_dpd = 0; m_lvl = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    compare(0, 0, "R1 reset state");

    cmd(8'h02, 40, 0, 0, "R4 program without latch");
    cmd(8'h06, 8, 0, 0, "R2 set latch");
    cmd(8'h02, 40, 0, 0, "R4 program accepted clears latch");
    cmd(8'h06, 8, 0, 0, "R2 set latch");
    cmd(8'h04, 8, 0, 0, "R2 clear latch");
    cmd(8'h03, 32, 0, 0, "R3 non-modify opcode gives no pulse");
    cmd(8'h06, 8, 0, 0, "R2 set latch");
    cmd(8'h02, 41, 0, 0, "R5 unaligned program rejected");
    cmd(8'h02, 32, 0, 0, "R5 short program rejected");
    cmd(8'h20, 24, 0, 0, "R5 short sector erase rejected");
    cmd(8'h01, 8, 0, 8'h0C, "R5 short status write rejected");
    cmd(8'h04, 8, 0, 0, "R2 clear latch");
    cmd(8'h06, 12, 0, 0, "R5 unaligned latch set ignored");
    cmd(8'h06, 8, 0, 0, "R2 set latch");
    cmd(8'h20, 32, 3, 0, "R4 sector erase accepted");

    for (int lvl = 0; lvl < 8; lvl++) begin
      cmd(8'h06, 8, 0, 0, "R2 set latch");
      cmd(8'h01, 16, 0, lvl << 2, "R8 status write loads level");
      for (int b = 0; b < 8; b++) begin
        cmd(8'h06, 8, 0, 0, "R2 set latch");
        cmd((b % 2 == 0) ? 8'h20 : 8'hD8, 32, b, 0, "R6 protect range");
      end
      cmd(8'h06, 8, 0, 0, "R2 set latch");
      cmd((lvl % 2 == 0) ? 8'hC7 : 8'h60, 8, 0, 0, "R7 chip erase vs level");
    end

    cmd(8'h06, 8, 0, 0, "R2 set latch");
    cmd(8'h01, 16, 0, 8'h80 | (2 << 2), "R8 set lock bit and level 2");
    wp_n = 1'b0;
    cmd(8'h06, 8, 0, 0, "R2 set latch");
    cmd(8'h01, 16, 0, 8'h00, "R8 status write blocked by pin");
    cmd(8'h02, 40, 7, 0, "R6 program into block 7 at level 2");
    cmd(8'h02, 40, 5, 0, "R6 program into block 5 at level 2");
    wp_n = 1'b1;
    cmd(8'h06, 8, 0, 0, "R2 set latch");
    cmd(8'h01, 16, 0, 8'h00, "R8 status write with pin high");
    wp_n = 1'b0;
    cmd(8'h06, 8, 0, 0, "R2 set latch");
    cmd(8'h01, 16, 0, 8'h04, "R8 unlocked status write with pin low");
    wp_n = 1'b1;

    cmd(8'h04, 8, 0, 0, "R2 clear latch");
    cmd(8'hB9, 8, 0, 0, "R9 enter deep power down");
    cmd(8'h06, 8, 0, 0, "R9 latch set ignored while asleep");
    cmd(8'h60, 8, 0, 0, "R9 chip erase rejected while asleep");
    cmd(8'hAB, 12, 0, 0, "R9 unaligned wake ignored");
    cmd(8'hAB, 32, 0, 0, "R9 wake");
    cmd(8'h06, 8, 0, 0, "R9 latch set works after wake");
    cmd(8'hB9, 8, 0, 0, "R9 enter deep power down with latch set");
    cmd(8'h02, 40, 0, 0, "R9 program rejected while asleep");
    cmd(8'hAB, 8, 0, 0, "R9 wake");
    cmd(8'h02, 40, 0, 0, "R9 latch kept through sleep, program accepted");

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule